// File: doc/BRIEF.md
# Same-Page Request Combiner for a Multi-Port TLB

This block sits in front of a translation lookaside buffer that can perform only a limited number of lookups per cycle. Several request lanes can each present a virtual page number (VPN) in the same cycle. The block compares the pages of all live requests with each other. Each set of requests that name the same page is treated as one group, and the group uses a single TLB lookup. The TLB result for that lookup is then copied to every lane in the group.

When there are more distinct pages than TLB lookup slots, the groups that do not get a slot keep their lanes occupied. Those lanes retry on the following cycles and take precedence over fresh work. A lane that is holding a request shows this by dropping its ready output, and any new input offered on that lane is ignored until the held request has been answered. The TLB is assumed to answer each lookup slot combinationally in the same cycle, so every lane response is produced in the cycle in which its lookup is issued.

Top module: `xlat_merge_front`

## Requirements
- R1: After reset no request is held: every `lane_ready` bit is 1, and with no valid input there is no lookup and no lane response.
- R2: All live requests that carry the same VPN in a cycle share one lookup slot, so that page appears on at most one valid lookup port.
- R3: The leader of a group is its lowest-numbered live lane. Valid lookups occupy ports 0, 1, ... without gaps, and are filled in priority order with leaders in ascending lane order within each priority class.
- R4: No more than N lookups are issued per cycle, and no two valid lookup ports carry the same VPN.
- R5: In the cycle of its lookup, every lane of a group raises `lane_resp_valid` and receives that lookup's hit flag and physical page number, including when the hit flag is 0 (miss).
- R6: A live request whose group gets no lookup is held. That lane's `lane_ready` is 0 from the next cycle until the cycle in which the held request is answered.
- R7: Groups that contain at least one held request are granted lookup ports before groups made only of new requests.
- R8: A new request whose VPN equals that of a held request joins the held request's group and is answered by the same lookup.
- R9: While `lane_ready` is 0, that lane's `lane_req_valid` and `lane_req_vpn` are ignored. The response for the lane is computed from the VPN it is holding.
- R10: The number of lookups in a cycle equals the smaller of N and the number of distinct pages among live requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_req_valid | input | M | Per-lane new request strobe |
| lane_req_vpn | input | M x VPN_W | Per-lane virtual page number |
| lane_ready | output | M | Lane can take a new request (not holding one) |
| lane_resp_valid | output | M | Lane's request answered this cycle |
| lane_resp_hit | output | M | TLB hit flag copied to the lane |
| lane_resp_ppn | output | M x PPN_W | Physical page number copied to the lane |
| tlb_lookup_valid | output | N | Lookup issued on TLB port |
| tlb_lookup_vpn | output | N x VPN_W | VPN for each TLB port |
| tlb_hit | input | N | Hit flag returned by each TLB port (same cycle) |
| tlb_ppn | input | N x PPN_W | Physical page number returned by each TLB port |

## Verification
The bench first sends four lanes that all name one page which misses. A single lookup with the miss copied to every lane separates real merging from per-lane lookups. Four distinct pages over two ports then show holding and the order of retries. Held lanes mixed with new ones show whether held work goes first, and a new request that names a held page shows whether held and new requests merge, with the leader still being the lowest lane. Fresh input driven on a holding lane must not change its answer. A long pseudo-random run that draws pages from three values creates many collisions, and each cycle is compared against a model TLB with unlimited ports.

// File: rtl/xmf_pkg.sv
// Shared definitions for the same-page request combiner.
// Assumes: nothing beyond standard SystemVerilog.
package xmf_pkg;

    // Origin of a lane's live request in the current cycle
    typedef enum logic {
        SRC_FRESH = 1'b0,
        SRC_HELD  = 1'b1
    } cand_src_e;

endpackage

// File: rtl/xmf_lane_hold.sv
// Per-lane holding register and candidate selection.
// What it does: presents one live request per lane, taken from the holding
// register when the lane holds a request and from the input otherwise.
// Assumes: served is only ever high for a lane whose candidate is live.
module xmf_lane_hold
    import xmf_pkg::*;
#(
    parameter int M     = 4,
    parameter int VPN_W = 20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [M-1:0]                req_valid,
    input  logic [M-1:0][VPN_W-1:0]     req_vpn,
    input  logic [M-1:0]                served,
    output logic [M-1:0]                cand_valid,
    output logic [M-1:0][VPN_W-1:0]     cand_vpn,
    output cand_src_e [M-1:0]           cand_src,
    output logic [M-1:0]                ready
);

    logic [M-1:0]            held_q;
    logic [M-1:0][VPN_W-1:0] held_vpn_q;

    for (genvar i = 0; i < M; i++) begin : g_lane
        // Choose the held request over the input when the lane holds one
        always_comb begin
            if (held_q[i]) begin
                cand_valid[i] = 1'b1;
                cand_vpn[i]   = held_vpn_q[i];
                cand_src[i]   = SRC_HELD;
            end else begin
                cand_valid[i] = req_valid[i];
                cand_vpn[i]   = req_vpn[i];
                cand_src[i]   = SRC_FRESH;
            end
        end

        // Keep every live request that was not answered this cycle
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held_q[i]     <= 1'b0;
                held_vpn_q[i] <= '0;
            end else begin
                held_q[i] <= cand_valid[i] & ~served[i];
                if (cand_valid[i] && !served[i]) begin
                    held_vpn_q[i] <= cand_vpn[i];
                end
            end
        end
    end

    assign ready = ~held_q;

endmodule

// File: rtl/xmf_page_match.sv
// Pairwise page comparison and group leader selection.
// What it does: finds, for each lane, the lowest live lane with the same VPN
// (its leader) and marks groups containing any held request.
// Assumes: invalid lanes never match anything.
module xmf_page_match
    import xmf_pkg::*;
#(
    parameter int M     = 4,
    parameter int VPN_W = 20,
    localparam int LANE_W = (M > 1) ? $clog2(M) : 1
) (
    input  logic [M-1:0]              cand_valid,
    input  logic [M-1:0][VPN_W-1:0]   cand_vpn,
    input  cand_src_e [M-1:0]         cand_src,
    output logic [M-1:0][LANE_W-1:0]  leader_idx,
    output logic [M-1:0]              is_leader,
    output logic [M-1:0]              group_held
);

    logic [M-1:0][M-1:0] same;

    for (genvar i = 0; i < M; i++) begin : g_row
        for (genvar j = 0; j < M; j++) begin : g_col
            // Equality of two live lanes' pages
            assign same[i][j] = cand_valid[i] & cand_valid[j]
                              & (cand_vpn[i] == cand_vpn[j]);
        end

        // Lowest matching lane wins: scan downwards so the last write is the lowest
        always_comb begin
            leader_idx[i] = LANE_W'(i);
            for (int j = M - 1; j >= 0; j--) begin
                if (same[i][j]) begin
                    leader_idx[i] = LANE_W'(j);
                end
            end
        end

        // A lane leads when it is live and no lower lane shares its page
        assign is_leader[i] = cand_valid[i] && (leader_idx[i] == LANE_W'(i));

        // The group is old when any member was held from an earlier cycle
        always_comb begin
            group_held[i] = 1'b0;
            for (int j = 0; j < M; j++) begin
                if (same[i][j] && cand_src[j] == SRC_HELD) begin
                    group_held[i] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/xmf_port_alloc.sv
// Lookup port allocation among group leaders.
// What it does: ranks leaders (held groups first, then ascending lane) and
// grants the first N ranks, placing rank r on port r.
// Assumes: group_held is consistent across all members of a group.
module xmf_port_alloc #(
    parameter int M     = 4,
    parameter int N     = 2,
    parameter int VPN_W = 20,
    localparam int RANK_W = $clog2(M + N + 1)
) (
    input  logic [M-1:0]              is_leader,
    input  logic [M-1:0]              group_held,
    input  logic [M-1:0][VPN_W-1:0]   cand_vpn,
    output logic [M-1:0][RANK_W-1:0]  rank,
    output logic [M-1:0]              granted,
    output logic [N-1:0]              lk_valid,
    output logic [N-1:0][VPN_W-1:0]   lk_vpn
);

    for (genvar i = 0; i < M; i++) begin : g_rank
        // Count leaders that precede this one in priority order
        always_comb begin
            rank[i] = '0;
            for (int k = 0; k < M; k++) begin
                if (k != i && is_leader[k]) begin
                    if ((group_held[k] && !group_held[i]) ||
                        (group_held[k] == group_held[i] && k < i)) begin
                        rank[i] = rank[i] + RANK_W'(1);
                    end
                end
            end
        end

        // Only the first N leaders get a lookup slot
        assign granted[i] = is_leader[i] && (rank[i] < RANK_W'(N));
    end

    for (genvar p = 0; p < N; p++) begin : g_port
        // Steer the leader whose rank equals this port number
        always_comb begin
            lk_valid[p] = 1'b0;
            lk_vpn[p]   = '0;
            for (int i = 0; i < M; i++) begin
                if (granted[i] && rank[i] == RANK_W'(p)) begin
                    lk_valid[p] = 1'b1;
                    lk_vpn[p]   = cand_vpn[i];
                end
            end
        end
    end

endmodule

// File: rtl/xmf_result_fanout.sv
// Result broadcast from lookup ports to lanes.
// What it does: each live lane whose leader was granted takes the hit flag
// and physical page from the leader's port in the same cycle.
// Assumes: the TLB answers each port combinationally.
module xmf_result_fanout #(
    parameter int M     = 4,
    parameter int N     = 2,
    parameter int PPN_W = 16,
    localparam int LANE_W = (M > 1) ? $clog2(M) : 1,
    localparam int RANK_W = $clog2(M + N + 1)
) (
    input  logic [M-1:0]              cand_valid,
    input  logic [M-1:0][LANE_W-1:0]  leader_idx,
    input  logic [M-1:0][RANK_W-1:0]  rank,
    input  logic [M-1:0]              granted,
    input  logic [N-1:0]              tlb_hit,
    input  logic [N-1:0][PPN_W-1:0]   tlb_ppn,
    output logic [M-1:0]              resp_valid,
    output logic [M-1:0]              resp_hit,
    output logic [M-1:0][PPN_W-1:0]   resp_ppn
);

    for (genvar i = 0; i < M; i++) begin : g_lane
        // Follow the leader to its port and copy that port's answer
        always_comb begin
            resp_valid[i] = 1'b0;
            resp_hit[i]   = 1'b0;
            resp_ppn[i]   = '0;
            for (int l = 0; l < M; l++) begin
                if (cand_valid[i] && leader_idx[i] == l[LANE_W-1:0] && granted[l]) begin
                    resp_valid[i] = 1'b1;
                    for (int p = 0; p < N; p++) begin
                        if (rank[l] == RANK_W'(p)) begin
                            resp_hit[i] = tlb_hit[p];
                            resp_ppn[i] = tlb_ppn[p];
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/xlat_merge_front.sv
// Top of the same-page request combiner.
// What it does: merges same-page requests from M lanes onto at most N TLB
// lookups per cycle, broadcasts results and holds lanes left without a port.
// Assumes: the TLB returns tlb_hit/tlb_ppn in the same cycle as the lookup.
module xlat_merge_front
    import xmf_pkg::*;
#(
    parameter int M     = 4,
    parameter int N     = 2,
    parameter int VPN_W = 20,
    parameter int PPN_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [M-1:0]             lane_req_valid,
    input  logic [M-1:0][VPN_W-1:0]  lane_req_vpn,
    output logic [M-1:0]             lane_ready,
    output logic [M-1:0]             lane_resp_valid,
    output logic [M-1:0]             lane_resp_hit,
    output logic [M-1:0][PPN_W-1:0]  lane_resp_ppn,
    output logic [N-1:0]             tlb_lookup_valid,
    output logic [N-1:0][VPN_W-1:0]  tlb_lookup_vpn,
    input  logic [N-1:0]             tlb_hit,
    input  logic [N-1:0][PPN_W-1:0]  tlb_ppn
);

    localparam int LANE_W = (M > 1) ? $clog2(M) : 1;
    localparam int RANK_W = $clog2(M + N + 1);

    logic [M-1:0]              cand_valid;
    logic [M-1:0][VPN_W-1:0]   cand_vpn;
    cand_src_e [M-1:0]         cand_src;
    logic [M-1:0][LANE_W-1:0]  leader_idx;
    logic [M-1:0]              is_leader;
    logic [M-1:0]              group_held;
    logic [M-1:0][RANK_W-1:0]  rank;
    logic [M-1:0]              granted;

    xmf_lane_hold #(.M(M), .VPN_W(VPN_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (lane_req_valid),
        .req_vpn    (lane_req_vpn),
        .served     (lane_resp_valid),
        .cand_valid (cand_valid),
        .cand_vpn   (cand_vpn),
        .cand_src   (cand_src),
        .ready      (lane_ready)
    );

    xmf_page_match #(.M(M), .VPN_W(VPN_W)) u_match (
        .cand_valid (cand_valid),
        .cand_vpn   (cand_vpn),
        .cand_src   (cand_src),
        .leader_idx (leader_idx),
        .is_leader  (is_leader),
        .group_held (group_held)
    );

    xmf_port_alloc #(.M(M), .N(N), .VPN_W(VPN_W)) u_alloc (
        .is_leader  (is_leader),
        .group_held (group_held),
        .cand_vpn   (cand_vpn),
        .rank       (rank),
        .granted    (granted),
        .lk_valid   (tlb_lookup_valid),
        .lk_vpn     (tlb_lookup_vpn)
    );

    xmf_result_fanout #(.M(M), .N(N), .PPN_W(PPN_W)) u_fan (
        .cand_valid (cand_valid),
        .leader_idx (leader_idx),
        .rank       (rank),
        .granted    (granted),
        .tlb_hit    (tlb_hit),
        .tlb_ppn    (tlb_ppn),
        .resp_valid (lane_resp_valid),
        .resp_hit   (lane_resp_hit),
        .resp_ppn   (lane_resp_ppn)
    );

endmodule

// File: rtl/xmf_checker.sv
// Assertion checker bound to xlat_merge_front.
// What it does: watches port timing and group consistency.
// Assumes: bound with the top's parameters.
module xmf_checker #(
    parameter int M     = 4,
    parameter int N     = 2,
    parameter int VPN_W = 20,
    parameter int PPN_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [M-1:0]             lane_req_valid,
    input logic [M-1:0]             lane_ready,
    input logic [M-1:0]             lane_resp_valid,
    input logic [M-1:0]             lane_resp_hit,
    input logic [M-1:0][PPN_W-1:0]  lane_resp_ppn,
    input logic [N-1:0]             tlb_lookup_valid,
    input logic [N-1:0][VPN_W-1:0]  tlb_lookup_vpn,
    input logic [M-1:0]             cand_valid,
    input logic [M-1:0][VPN_W-1:0]  cand_vpn
);

    AST_READY_AFTER_RESET: assert property (@(posedge clk)
        $rose(rst_n) |-> (lane_ready == {M{1'b1}}));  // R1

    AST_PORTS_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((tlb_lookup_valid & (tlb_lookup_valid + 1'b1)) == '0));  // R3

    AST_WORK_CONSERVING: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cand_valid & ~lane_resp_valid)) |-> (&tlb_lookup_valid));  // R10

    for (genvar p = 0; p < N; p++) begin : g_pp
        for (genvar q = p + 1; q < N; q++) begin : g_pq
            AST_NO_DUP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
                (tlb_lookup_valid[p] && tlb_lookup_valid[q]) |->
                (tlb_lookup_vpn[p] != tlb_lookup_vpn[q]));  // R4
        end
    end

    for (genvar i = 0; i < M; i++) begin : g_lane
        AST_UNSERVED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_req_valid[i] && lane_ready[i] && !lane_resp_valid[i]) |=> !lane_ready[i]);  // R6

        AST_HOLD_UNTIL_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
            (!lane_ready[i] && !lane_resp_valid[i]) |=> !lane_ready[i]);  // R9

        AST_ANSWER_FREES: assert property (@(posedge clk) disable iff (!rst_n)
            lane_resp_valid[i] |=> lane_ready[i]);  // R6

        for (genvar j = i + 1; j < M; j++) begin : g_pair
            AST_GROUP_SAME_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
                (lane_resp_valid[i] && lane_resp_valid[j] && cand_vpn[i] == cand_vpn[j]) |->
                (lane_resp_hit[i] == lane_resp_hit[j] && lane_resp_ppn[i] == lane_resp_ppn[j]));  // R5

            AST_GROUP_SERVED_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
                (cand_valid[i] && cand_valid[j] && cand_vpn[i] == cand_vpn[j]) |->
                (lane_resp_valid[i] == lane_resp_valid[j]));  // R2
        end
    end

endmodule

bind xlat_merge_front xmf_checker #(.M(M), .N(N), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_xmf_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .lane_req_valid   (lane_req_valid),
    .lane_ready       (lane_ready),
    .lane_resp_valid  (lane_resp_valid),
    .lane_resp_hit    (lane_resp_hit),
    .lane_resp_ppn    (lane_resp_ppn),
    .tlb_lookup_valid (tlb_lookup_valid),
    .tlb_lookup_vpn   (tlb_lookup_vpn),
    .cand_valid       (cand_valid),
    .cand_vpn         (cand_vpn)
);

// File: tb/tb_xlat_merge_front.sv
// Directed bench for xlat_merge_front with a model TLB of unlimited ports.
module tb_xlat_merge_front;

    localparam int M = 4;
    localparam int N = 2;
    localparam int VPN_W = 20;
    localparam int PPN_W = 16;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [M-1:0]             req_valid = '0;
    logic [M-1:0][VPN_W-1:0]  req_vpn = '0;
    logic [M-1:0]             lane_ready;
    logic [M-1:0]             resp_valid;
    logic [M-1:0]             resp_hit;
    logic [M-1:0][PPN_W-1:0]  resp_ppn;
    logic [N-1:0]             lk_valid;
    logic [N-1:0][VPN_W-1:0]  lk_vpn;
    logic [N-1:0]             tlb_hit;
    logic [N-1:0][PPN_W-1:0]  tlb_ppn;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // bench copy of which lanes hold a request
    logic [M-1:0]            b_held = '0;
    logic [M-1:0][VPN_W-1:0] b_hvpn = '0;
    // snapshot of the last cycle for scenario checks
    logic [M-1:0]            last_served;
    int                      last_nlk;
    logic [VPN_W-1:0]        last_port0;
    logic [M-1:0][PPN_W-1:0] last_ppn;
    logic [M-1:0]            last_hit;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xlat_merge_front #(.M(M), .N(N), .VPN_W(VPN_W), .PPN_W(PPN_W)) dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .lane_req_valid   (req_valid),
        .lane_req_vpn     (req_vpn),
        .lane_ready       (lane_ready),
        .lane_resp_valid  (resp_valid),
        .lane_resp_hit    (resp_hit),
        .lane_resp_ppn    (resp_ppn),
        .tlb_lookup_valid (lk_valid),
        .tlb_lookup_vpn   (lk_vpn),
        .tlb_hit          (tlb_hit),
        .tlb_ppn          (tlb_ppn)
    );

    function automatic logic ref_hit(input logic [VPN_W-1:0] v);
        return (v[1:0] != 2'b11);
    endfunction

    function automatic logic [PPN_W-1:0] ref_ppn(input logic [VPN_W-1:0] v);
        logic [VPN_W-1:0] t;
        t = (v * 20'd3) ^ 20'h0a5a5;
        return t[PPN_W-1:0];
    endfunction

    // Model TLB: every port answers in the same cycle
    always_comb begin
        for (int p = 0; p < N; p++) begin
            tlb_hit[p] = ref_hit(lk_vpn[p]);
            tlb_ppn[p] = ref_ppn(lk_vpn[p]);
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, predict with an unlimited-port model, compare, advance
    task automatic run_cycle(input logic [M-1:0] v, input logic [M-1:0][VPN_W-1:0] vp);
        logic [M-1:0] cv, cold, exps;
        logic [M-1:0][VPN_W-1:0] cvpn;
        int ldr[M];
        int gold[M];
        int order[M];
        int ng;
        int expn;
        @(negedge clk);
        req_valid = v;
        req_vpn   = vp;
        for (int i = 0; i < M; i++) begin
            cold[i] = b_held[i];
            cv[i]   = b_held[i] | v[i];
            cvpn[i] = b_held[i] ? b_hvpn[i] : vp[i];
        end
        for (int i = 0; i < M; i++) begin
            ldr[i] = i;
            for (int j = i - 1; j >= 0; j--) begin
                if (cv[i] && cv[j] && cvpn[i] == cvpn[j]) ldr[i] = j;
            end
        end
        for (int i = 0; i < M; i++) begin
            gold[i] = 0;
            for (int k = 0; k < M; k++) begin
                if (cv[k] && ldr[k] == i && cold[k]) gold[i] = 1;
            end
        end
        ng = 0;
        for (int i = 0; i < M; i++) if (cv[i] && ldr[i] == i && gold[i] == 1) begin order[ng] = i; ng++; end
        for (int i = 0; i < M; i++) if (cv[i] && ldr[i] == i && gold[i] == 0) begin order[ng] = i; ng++; end
        expn = (ng < N) ? ng : N;
        exps = '0;
        for (int r = 0; r < expn; r++) begin
            for (int i = 0; i < M; i++) if (cv[i] && ldr[i] == order[r]) exps[i] = 1'b1;
        end
        #(CLK_PERIOD / 4);
        chk(lane_ready == ~b_held, "R6", "lane_ready", 64'(lane_ready), 64'(~b_held));
        chk($countones(lk_valid) == expn, "R10", "lookup count", 64'($countones(lk_valid)), 64'(expn));
        for (int r = 0; r < expn; r++) begin
            chk(lk_valid[r] && lk_vpn[r] == cvpn[order[r]], "R3", "port vpn",
                64'(lk_vpn[r]), 64'(cvpn[order[r]]));
        end
        chk(resp_valid == exps, "R7", "served lanes", 64'(resp_valid), 64'(exps));
        for (int i = 0; i < M; i++) begin
            if (exps[i]) begin
                chk(resp_hit[i] == ref_hit(cvpn[i]), "R5", "lane hit",
                    64'(resp_hit[i]), 64'(ref_hit(cvpn[i])));
                chk(resp_ppn[i] == ref_ppn(cvpn[i]), "R5", "lane ppn",
                    64'(resp_ppn[i]), 64'(ref_ppn(cvpn[i])));
            end
        end
        last_served = resp_valid;
        last_nlk    = $countones(lk_valid);
        last_port0  = lk_vpn[0];
        last_ppn    = resp_ppn;
        last_hit    = resp_hit;
        @(posedge clk);
        for (int i = 0; i < M; i++) begin
            b_held[i] = cv[i] & ~exps[i];
            if (b_held[i]) b_hvpn[i] = cvpn[i];
        end
    endtask

    task automatic drain();
        for (int k = 0; k < 3; k++) run_cycle('0, '0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        #(CLK_PERIOD / 4);
        chk(lane_ready == {M{1'b1}}, "R1", "ready after reset", 64'(lane_ready), 64'hf);
        chk(lk_valid == '0, "R1", "no lookup", 64'(lk_valid), 64'h0);
        chk(resp_valid == '0, "R1", "no response", 64'(resp_valid), 64'h0);
    endtask

    task automatic t_same_page();
        run_cycle(4'b1111, {20'h00123, 20'h00123, 20'h00123, 20'h00123});
        chk(last_nlk == 1, "R2", "one lookup for shared page", 64'(last_nlk), 64'd1);
        chk(last_served == 4'b1111, "R2", "all lanes answered", 64'(last_served), 64'hf);
        chk(last_hit == 4'b0000, "R5", "miss copied to all", 64'(last_hit), 64'h0);
        drain();
    endtask

    task automatic t_distinct();
        run_cycle(4'b1111, {20'h00404, 20'h00303, 20'h00202, 20'h00101});
        chk(last_served == 4'b0011, "R6", "low lanes first", 64'(last_served), 64'h3);
        run_cycle('0, '0);
        chk(last_served == 4'b1100, "R6", "held lanes later", 64'(last_served), 64'hc);
        drain();
    endtask

    task automatic t_priority();
        run_cycle(4'b1111, {20'h00404, 20'h00303, 20'h00202, 20'h00101});
        run_cycle(4'b0011, {20'h0, 20'h0, 20'h00606, 20'h00505});
        chk(last_served == 4'b1100, "R7", "held before fresh", 64'(last_served), 64'hc);
        chk(last_port0 == 20'h00303, "R7", "port 0 carries held page", 64'(last_port0), 64'h303);
        run_cycle('0, '0);
        chk(last_served == 4'b0011, "R7", "fresh served next", 64'(last_served), 64'h3);
        drain();
    endtask

    task automatic t_merge();
        run_cycle(4'b1111, {20'h00404, 20'h00303, 20'h00202, 20'h00101});
        run_cycle(4'b0011, {20'h0, 20'h0, 20'h00707, 20'h00404});
        chk(last_served == 4'b1101, "R8", "fresh joins held page", 64'(last_served), 64'hd);
        chk(last_port0 == 20'h00404, "R8", "merged group on port 0", 64'(last_port0), 64'h404);
        drain();
    endtask

    task automatic t_ignore();
        run_cycle(4'b1111, {20'h00404, 20'h00303, 20'h00202, 20'h00101});
        run_cycle(4'b1100, {20'h00999, 20'h00999, 20'h0, 20'h0});
        chk(last_served == 4'b1100, "R9", "held lanes answered", 64'(last_served), 64'hc);
        chk(last_ppn[2] == ref_ppn(20'h00303), "R9", "lane 2 uses held page",
            64'(last_ppn[2]), 64'(ref_ppn(20'h00303)));
        drain();
    endtask

    task automatic t_random();
        logic [31:0] lfsr = 32'h1234_5678;
        logic [M-1:0] v;
        logic [M-1:0][VPN_W-1:0] vp;
        logic [VPN_W-1:0] pages[3];
        pages[0] = 20'h0a000; pages[1] = 20'h0a013; pages[2] = 20'h0b002;
        for (int c = 0; c < 400; c++) begin
            for (int i = 0; i < M; i++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                v[i] = lfsr[3] | lfsr[7];
                vp[i] = pages[lfsr[9:8] % 3];
            end
            run_cycle(v, vp);
        end
        drain();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_same_page();
        t_distinct();
        t_priority();
        t_merge();
        t_ignore();
        t_random();
        finish_run();
    end

endmodule